// File: doc/BRIEF.md
# Priority Bus Grant Arbiter

This block sits on the processor side of a shared peripheral bus and decides which requester receives the bus next. It watches a single wired-OR DMA request line and four interrupt request lines at levels 4 through 7. From these it drives exactly one grant at a time onto the matching serial grant chain. A DMA request always beats every interrupt level. An interrupt level competes only when it is strictly above the processor's current 3-bit priority.

The device at the far end of a grant chain confirms receipt on a single shared selection-acknowledge line. The arbiter takes its grant away as soon as that acknowledge is seen. If no acknowledge arrives within a parameterised number of clock cycles, the arbiter withdraws the grant and raises a one-cycle no-acknowledge error pulse. It will not start a new grant while the acknowledge from the previous winner is still asserted.

Arbitration does not wait for the bus to become idle. The arbiter may pick and grant the next master while the present master still holds bus-busy, so selection overlaps the transfer in progress.

Top module: `bga_arbiter`

## Requirements
- R1: After reset, `dma_grant`, every `irq_grant` bit and `nak_err` are 0.
- R2: No more than one of `dma_grant` and `irq_grant[3:0]` is high in any cycle.
- R3: A grant is chosen in the idle state when `ack_in` is low and at least one request is eligible. The grant appears on the outputs one clock edge after that state is sampled.
- R4: Whenever `dma_req` is high at the issuing edge, the grant goes to `dma_grant`, whatever the interrupt requests or `cpu_pri` are.
- R5: `irq_req[i]` stands for level 4+i and drives `irq_grant[i]`. Among eligible levels the highest number wins, so bit 3 (level 7) ranks above bit 0 (level 4).
- R6: An interrupt level L is eligible only if L > `cpu_pri`. A pending level at or below `cpu_pri` never gets a grant.
- R7: A grant that is high while `ack_in` is high is low from the next clock edge onward.
- R8: While `ack_in` stays high after a grant has been removed, no new grant is issued, even if requests are pending.
- R9: If `ack_in` stays low, a grant stays high for exactly `ACK_TIMEOUT` cycles. It is then removed, and `nak_err` is high for the single cycle that follows.
- R10: An acknowledge that arrives in the last cycle of the timeout window removes the grant without any `nak_err`.
- R11: `bus_busy` has no effect on choosing or issuing a grant, so a grant can be issued while another master holds the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | Wired-OR DMA request |
| irq_req | input | 4 | Interrupt requests; bit i is level 4+i |
| ack_in | input | 1 | Shared selection acknowledge from the grant chains |
| bus_busy | input | 1 | Another master currently holds the bus |
| cpu_pri | input | 3 | Current processor priority level |
| dma_grant | output | 1 | Grant onto the DMA grant chain |
| irq_grant | output | 4 | Grants onto the interrupt chains; bit i is level 4+i |
| nak_err | output | 1 | One-cycle pulse when a grant went unacknowledged |

## Verification
The hardest cases to reach are at the two edges of the acknowledge window. One is a grant that expires with no acknowledge. The other is an acknowledge that lands in the very last cycle before expiry, which must stop the error pulse. The bench builds the arbiter with a short timeout and counts grant cycles one by one from the ports. It then places the acknowledge exactly on the final cycle of the window. A full sweep over the DMA request, all sixteen interrupt patterns, all eight priority values and both bus-busy states covers selection and masking. Within that sweep, the acknowledge is held high past the grant's removal to show that requests still pending are not granted.

// File: rtl/bga_pkg.sv
package bga_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;

  // A level may compete only when it is strictly above the processor priority.
  function automatic logic lvl_above(input int unsigned lvl, input int unsigned pri);
    return lvl > pri;
  endfunction

  // Timer limit value for a timeout of n cycles (count runs 0 .. n-1).
  function automatic int unsigned last_count(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/bga_select.sv
module bga_select #(
  parameter int unsigned NUM_LVL  = 4,
  parameter int unsigned LVL_BASE = 4,
  parameter int unsigned PRI_W    = 3
) (
  input  logic               dma_req,
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic [PRI_W-1:0]   cpu_pri,
  output logic               win_dma,
  output logic [NUM_LVL-1:0] win_irq,
  output logic               any_win
);
  import bga_pkg::*;

  logic [NUM_LVL-1:0] eligible;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_elig
    assign eligible[g] = irq_req[g] & lvl_above(LVL_BASE + g, int'(cpu_pri));
  end

  // Scan from the lowest level upward; a later (higher) hit overrides.
  logic [NUM_LVL-1:0] irq_pick;
  always_comb begin
    irq_pick = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (eligible[i]) begin
        irq_pick    = '0;
        irq_pick[i] = 1'b1;
      end
    end
  end

  assign win_dma = dma_req;
  assign win_irq = dma_req ? '0 : irq_pick;
  assign any_win = dma_req | (|eligible);

endmodule

// File: rtl/bga_timer.sv
module bga_timer #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expire
);
  import bga_pkg::*;

  localparam int unsigned CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(last_count(TIMEOUT));

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || expire) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bga_arbiter.sv
module bga_arbiter #(
  parameter int unsigned NUM_LVL     = 4,
  parameter int unsigned LVL_BASE    = 4,
  parameter int unsigned PRI_W       = 3,
  parameter int unsigned ACK_TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_req,
  input  logic [NUM_LVL-1:0] irq_req,
  input  logic               ack_in,
  input  logic               bus_busy,
  input  logic [PRI_W-1:0]   cpu_pri,
  output logic               dma_grant,
  output logic [NUM_LVL-1:0] irq_grant,
  output logic               nak_err
);
  import bga_pkg::*;

  arb_state_e         state_q;
  logic               dma_q;
  logic [NUM_LVL-1:0] irq_q;
  logic               nak_q;

  logic               win_dma;
  logic [NUM_LVL-1:0] win_irq;
  logic               any_win;

  // Named events for the checker.
  logic issue_grant;
  logic ack_seen;
  logic timed_out;
  logic holding;

  bga_select #(
    .NUM_LVL (NUM_LVL),
    .LVL_BASE(LVL_BASE),
    .PRI_W   (PRI_W)
  ) u_select (
    .dma_req(dma_req),
    .irq_req(irq_req),
    .cpu_pri(cpu_pri),
    .win_dma(win_dma),
    .win_irq(win_irq),
    .any_win(any_win)
  );

  assign holding     = (state_q == ARB_HOLD);
  assign issue_grant = !holding && !ack_in && any_win;
  assign ack_seen    = holding && ack_in;

  bga_timer #(
    .TIMEOUT(ACK_TIMEOUT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (holding && !ack_in),
    .clr   (!holding || ack_in),
    .expire(timed_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      dma_q   <= 1'b0;
      irq_q   <= '0;
      nak_q   <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      if (issue_grant) begin
        state_q <= ARB_HOLD;
        dma_q   <= win_dma;
        irq_q   <= win_irq;
      end else if (ack_seen || timed_out) begin
        state_q <= ARB_IDLE;
        dma_q   <= 1'b0;
        irq_q   <= '0;
        nak_q   <= timed_out && !ack_seen;
      end
    end
  end

  assign dma_grant = dma_q;
  assign irq_grant = irq_q;
  assign nak_err   = nak_q;

endmodule

// File: rtl/bga_arbiter_chk.sv
module bga_arbiter_chk #(
  parameter int unsigned NUM_LVL     = 4,
  parameter int unsigned LVL_BASE    = 4,
  parameter int unsigned PRI_W       = 3,
  parameter int unsigned ACK_TIMEOUT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dma_req,
  input logic [NUM_LVL-1:0] irq_req,
  input logic               ack_in,
  input logic               bus_busy,
  input logic [PRI_W-1:0]   cpu_pri,
  input logic               dma_grant,
  input logic [NUM_LVL-1:0] irq_grant,
  input logic               nak_err,
  input logic               issue_grant,
  input logic               timed_out
);
  logic any_grant;
  assign any_grant = dma_grant | (|irq_grant);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_grant, irq_grant})); // R2

  AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_grant && dma_req) |=> dma_grant); // R4

  AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && ack_in) |=> !any_grant); // R7

  AST_NO_GRANT_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_grant && ack_in) |=> !any_grant); // R8

  AST_NAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nak_err |=> !nak_err); // R9

  AST_NAK_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !ack_in) |=> (nak_err && !any_grant)); // R9

  AST_OVERLAP_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_grant && !ack_in && dma_req && bus_busy) |=> dma_grant); // R11

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_mask
    AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_grant && !ack_in && irq_req[g] && !dma_req &&
       (int'(cpu_pri) >= int'(LVL_BASE + g))) |=> !irq_grant[g]); // R6
  end

  // Grant hold window, checked with a counter instead of a long $past.
  int unsigned hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= 0;
    end else begin
      hold_cnt <= any_grant ? hold_cnt + 1 : 0;
      AST_HOLD_WINDOW: assert (hold_cnt <= ACK_TIMEOUT); // R9
    end
  end

endmodule

bind bga_arbiter bga_arbiter_chk #(
  .NUM_LVL    (NUM_LVL),
  .LVL_BASE   (LVL_BASE),
  .PRI_W      (PRI_W),
  .ACK_TIMEOUT(ACK_TIMEOUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_req    (dma_req),
  .irq_req    (irq_req),
  .ack_in     (ack_in),
  .bus_busy   (bus_busy),
  .cpu_pri    (cpu_pri),
  .dma_grant  (dma_grant),
  .irq_grant  (irq_grant),
  .nak_err    (nak_err),
  .issue_grant(issue_grant),
  .timed_out  (timed_out)
);

// File: tb/bga_arbiter_tb.sv
module bga_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_req = 1'b0;
  logic [3:0] irq_req = '0;
  logic       ack_in = 1'b0;
  logic       bus_busy = 1'b0;
  logic [2:0] cpu_pri = '0;
  logic       dma_grant;
  logic [3:0] irq_grant;
  logic       nak_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bga_arbiter #(
    .NUM_LVL(4), .LVL_BASE(4), .PRI_W(3), .ACK_TIMEOUT(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .irq_req(irq_req),
    .ack_in(ack_in), .bus_busy(bus_busy), .cpu_pri(cpu_pri),
    .dma_grant(dma_grant), .irq_grant(irq_grant), .nak_err(nak_err)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {nak_err, dma_grant, irq_grant};
  endfunction

  // Expected winner as {nak, dma, irq[3:0]}, worked out from the priority rules.
  function automatic logic [5:0] expect_win(logic d, logic [3:0] r, logic [2:0] p);
    logic [5:0] e;
    e = '0;
    if (d) e[4] = 1'b1;
    else begin
      for (int lv = 7; lv >= 4; lv--) begin
        if (e[3:0] == 0 && r[lv-4] && lv > int'(p)) e[lv-4] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp;
    @(negedge clk);
    check("R1 reset", outs(), 6'b0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after release", outs(), 6'b0);

    // Full sweep over requests, priority and bus-busy.
    for (int c = 0; c < 512; c++) begin
      dma_req  = c[0];
      bus_busy = c[1];
      irq_req  = c[5:2];
      cpu_pri  = c[8:6];
      exp = expect_win(dma_req, irq_req, cpu_pri);
      tick();
      check(dma_req ? "R4 dma first" : "R3 R5 R6 R11 select", outs(), exp);
      if (exp != 0) begin
        ack_in = 1'b1;
        tick();
        check("R7 drop on ack", outs(), 6'b0);
        tick();
        check("R8 none while ack", outs(), 6'b0);
      end
      ack_in = 1'b0; dma_req = 1'b0; irq_req = '0;
      tick();
      check("R2 idle", outs(), 6'b0);
    end

    // Timeout without acknowledge.
    cpu_pri = 3'd0;
    irq_req = 4'b0100;
    tick();
    for (int k = 0; k < TMO; k++) begin
      check("R9 held", outs(), 6'b000100);
      if (k < TMO-1) tick();
    end
    irq_req = '0;
    tick();
    check("R9 nak pulse", outs(), 6'b100000);
    tick();
    check("R9 nak one cycle", outs(), 6'b0);

    // Acknowledge on the last cycle of the window.
    dma_req = 1'b1;
    tick();
    for (int k = 0; k < TMO-1; k++) begin
      check("R10 held", outs(), 6'b010000);
      tick();
    end
    check("R10 last cycle", outs(), 6'b010000);
    ack_in = 1'b1; dma_req = 1'b0;
    tick();
    check("R10 no nak", outs(), 6'b0);
    ack_in = 1'b0;
    tick();
    check("R10 quiet", outs(), 6'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule